// File: doc/BRIEF.md
# Protected Watchdog with Deferred Configuration

This block is a 16-bit watchdog counter whose settings are guarded by a one-bit protection flag. Software clears the flag, writes its wishes into a control register, and then sets the flag again. Only that write commits the staged wishes into the live settings. The settings are enable/disable and a choice between a fast and a slow count rate. The same write that commits them also clears one entry of an eight-bit bank of self-check failure flags, chosen by an index field in the control register.

The counter advances on each prescaler tick while it is enabled. When an increment brings it to 0xFFFF, it raises a timeout for exactly one cycle and then holds there. A service strobe loads the counter from a reload input at any time. A read-only status word shows:

- the count
- the failure flags
- the live settings
- a self-check-mode indicator
- the protection flag

Top module: `wdg_protected`

## Requirements
- R1: While reset is held, the following values are loaded. The status count field [31:16] becomes 0xFFFC. The live disable bit (status bit 3) and the live fast-rate bit (status bit 2) become 0, so the counter is enabled at the slow rate. The protection flag (status bit 0) becomes 0. The control register becomes 0 and the timeout becomes 0. The failure flags (status [15:8]) and the self-check indicator (status bit 1) all take the value of `selfchk_mode_i`.
- R2: Only control bits 3 (disable request), 2 (fast-rate request) and [10:8] (clear index) store written data. Every other control bit reads 0.
- R3: A control write made while the protection flag is 1 leaves bits 3 and 2 unchanged. The index field [10:8] is written regardless of the flag.
- R4: A write of 1 to the protection flag is a commit. On the commit edge, status bit 3 takes control bit 3 and status bit 2 takes control bit 2, using the control register as it stood before that edge. A write of 0, or no write, leaves status bits 3 and 2 unchanged.
- R5: While enabled, the count increases by 1 every 256 cycles at the fast rate and every 16384 cycles at the slow rate. The prescaler is held at zero while the counter is disabled. It also restarts when a commit changes the rate. In both cases the first increment comes one full period after the commit.
- R6: `timeout_o` is high for exactly one cycle. That cycle is the first one in which an increment has made the count 0xFFFF. The count then stays at 0xFFFF.
- R7: A service strobe makes the count equal to `reload_i` on the next cycle. The strobe takes priority over a tick.
- R8: Each commit clears failure flag N, where N is control [10:8]. Failure flags are never set except by reset.
- R9: The self-check indicator clears only on a commit, and only if `selfchk_mode_i` is low and all failure flags are zero after that commit's clear. Otherwise it holds its value.
- R10: While the live disable bit is 1 and no service strobe is given, the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| selfchk_mode_i | input | 1 | Self-check mode selection; sampled at reset and at commits |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control register write data |
| ctrl_rdata_o | output | 32 | Control register contents |
| prot_wr_i | input | 1 | Protection flag write strobe |
| prot_wdata_i | input | 1 | Protection flag write value; 1 commits |
| service_i | input | 1 | Service strobe: reload the counter |
| reload_i | input | 16 | Value loaded by a service strobe |
| status_o | output | 32 | Count, failure flags, live settings, indicator, flag |
| timeout_o | output | 1 | One-cycle pulse when the count first reaches 0xFFFF |

## Verification
The hardest case to reach is the prescaler restart on a rate change. The restart is only visible if the prescaler has run partway through a period at the old rate before the commit arrives. The stimulus therefore enables the counter at the fast rate and lets it run for an odd number of cycles. It then stages the slow rate, and later the fast rate again, and commits each change. It checks that the count is still unchanged one cycle before a full new period has passed, and that it has moved exactly at the full period. The self-check exit is reached by clearing the flags one index per commit, with the mode input low. Random sequences of control writes, flag writes and mode changes follow, checked against a model.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int CNT_W = 16;
    localparam int ERR_N = 8;
    localparam int IDX_W = $clog2(ERR_N);
    localparam logic [CNT_W-1:0] CNT_RESET = 16'hFFFC;
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [ERR_N-1:0] err;
        logic [3:0]       rsv;
        logic             dis;
        logic             fast;
        logic             scm;
        logic             prot;
    } wdg_status_t;

    typedef struct packed {
        logic [20:0]      rsv_hi;
        logic [IDX_W-1:0] idx;
        logic [3:0]       rsv_mid;
        logic             dis_req;
        logic             fast_req;
        logic [1:0]       rsv_lo;
    } wdg_ctrl_t;

    typedef struct packed {
        logic dis;
        logic fast;
    } wdg_setting_t;

    // Merge a control write: index always accepted, setting requests only when unlocked.
    function automatic wdg_ctrl_t ctrl_merge(input logic [31:0] wdata,
                                             input wdg_ctrl_t cur,
                                             input logic locked);
        wdg_ctrl_t w;
        wdg_ctrl_t r;
        w = wdg_ctrl_t'(wdata);
        r = '0;
        r.idx      = w.idx;
        r.dis_req  = locked ? cur.dis_req  : w.dis_req;
        r.fast_req = locked ? cur.fast_req : w.fast_req;
        return r;
    endfunction

endpackage

// File: rtl/wdg_cfg.sv
module wdg_cfg import wdg_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             selfchk_mode_i,
    input  logic             ctrl_wr_i,
    input  logic [31:0]      ctrl_wdata_i,
    input  logic             prot_wr_i,
    input  logic             prot_wdata_i,
    output wdg_ctrl_t        ctrl_o,
    output logic             prot_o,
    output wdg_setting_t     set_o,
    output logic [ERR_N-1:0] err_o,
    output logic             scm_o,
    output logic             restart_o
);

    wdg_ctrl_t        ctrl_q;
    wdg_setting_t     set_q;
    logic             prot_q;
    logic             scm_q;
    logic [ERR_N-1:0] err_q;
    logic [ERR_N-1:0] err_nx;
    logic             commit;

    assign commit = prot_wr_i && prot_wdata_i;

    // Per-flag clear decode
    for (genvar g = 0; g < ERR_N; g++) begin : g_err
        assign err_nx[g] = err_q[g] & ~(commit && (ctrl_q.idx == IDX_W'(g)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            prot_q <= 1'b0;
            set_q  <= '0;
            err_q  <= {ERR_N{selfchk_mode_i}};
            scm_q  <= selfchk_mode_i;
        end else begin
            if (ctrl_wr_i) begin
                ctrl_q <= ctrl_merge(ctrl_wdata_i, ctrl_q, prot_q);
            end
            if (prot_wr_i) begin
                prot_q <= prot_wdata_i;
            end
            if (commit) begin
                set_q.dis  <= ctrl_q.dis_req;
                set_q.fast <= ctrl_q.fast_req;
                err_q      <= err_nx;
                if (scm_q && !selfchk_mode_i && (err_nx == '0)) begin
                    scm_q <= 1'b0;
                end
            end
        end
    end

    assign restart_o = commit && (ctrl_q.fast_req != set_q.fast);
    assign ctrl_o    = ctrl_q;
    assign prot_o    = prot_q;
    assign set_o     = set_q;
    assign err_o     = err_q;
    assign scm_o     = scm_q;

endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int DIV_SLOW = 16384,
    parameter int DIV_FAST = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic fast_i,
    input  logic restart_i,
    output logic tick_o
);

    localparam int PRE_W = $clog2(DIV_SLOW);
    localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'(DIV_SLOW - 1);
    localparam logic [PRE_W-1:0] LIM_FAST = PRE_W'(DIV_FAST - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    assign limit  = fast_i ? LIM_FAST : LIM_SLOW;
    assign tick_o = en_i && (pre_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !en_i || restart_i || tick_o) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter import wdg_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             service_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             timeout_o
);

    logic [CNT_W-1:0] count_q;
    logic             to_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= CNT_RESET;
            to_q    <= 1'b0;
        end else begin
            to_q <= 1'b0;
            if (service_i) begin
                count_q <= reload_i;
            end else if (tick_i && (count_q != CNT_MAX)) begin
                count_q <= count_q + 1'b1;
                to_q    <= ((count_q + 1'b1) == CNT_MAX);
            end
        end
    end

    assign count_o   = count_q;
    assign timeout_o = to_q;

endmodule

// File: rtl/wdg_protected.sv
module wdg_protected import wdg_pkg::*; #(
    parameter int DIV_SLOW = 16384,
    parameter int DIV_FAST = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             selfchk_mode_i,
    input  logic             ctrl_wr_i,
    input  logic [31:0]      ctrl_wdata_i,
    output logic [31:0]      ctrl_rdata_o,
    input  logic             prot_wr_i,
    input  logic             prot_wdata_i,
    input  logic             service_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [31:0]      status_o,
    output logic             timeout_o
);

    wdg_ctrl_t        ctrl;
    wdg_setting_t     live;
    logic             prot;
    logic             scm;
    logic [ERR_N-1:0] err;
    logic             restart;
    logic             tick;
    logic [CNT_W-1:0] count;
    wdg_status_t      st;

    wdg_cfg i_cfg (
        .clk            (clk),
        .rst            (rst),
        .selfchk_mode_i (selfchk_mode_i),
        .ctrl_wr_i      (ctrl_wr_i),
        .ctrl_wdata_i   (ctrl_wdata_i),
        .prot_wr_i      (prot_wr_i),
        .prot_wdata_i   (prot_wdata_i),
        .ctrl_o         (ctrl),
        .prot_o         (prot),
        .set_o          (live),
        .err_o          (err),
        .scm_o          (scm),
        .restart_o      (restart)
    );

    wdg_prescaler #(
        .DIV_SLOW (DIV_SLOW),
        .DIV_FAST (DIV_FAST)
    ) i_pre (
        .clk       (clk),
        .rst       (rst),
        .en_i      (!live.dis),
        .fast_i    (live.fast),
        .restart_i (restart),
        .tick_o    (tick)
    );

    wdg_counter i_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .service_i (service_i),
        .reload_i  (reload_i),
        .count_o   (count),
        .timeout_o (timeout_o)
    );

    always_comb begin
        st       = '0;
        st.count = count;
        st.err   = err;
        st.dis   = live.dis;
        st.fast  = live.fast;
        st.scm   = scm;
        st.prot  = prot;
    end

    assign status_o     = st;
    assign ctrl_rdata_o = ctrl;

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker import wdg_pkg::*; (
    input logic             clk,
    input logic             rst,
    input logic             ctrl_wr_i,
    input logic [31:0]      ctrl_rdata_o,
    input logic             prot_wr_i,
    input logic             prot_wdata_i,
    input logic             service_i,
    input logic [CNT_W-1:0] reload_i,
    input logic [31:0]      status_o,
    input logic             timeout_o
);

    a_r3_locked_requests: assert property (@(posedge clk) disable iff (rst)
        (status_o[0] && ctrl_wr_i) |=> (ctrl_rdata_o[3:2] == $past(ctrl_rdata_o[3:2])));

    a_r4_commit_loads: assert property (@(posedge clk) disable iff (rst)
        (prot_wr_i && prot_wdata_i) |=> (status_o[3:2] == $past(ctrl_rdata_o[3:2])));

    a_r4_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
        !(prot_wr_i && prot_wdata_i) |=> $stable(status_o[3:2]));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);

    a_r6_pulse_at_max: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> (status_o[31:16] == CNT_MAX));

    a_r7_service_load: assert property (@(posedge clk) disable iff (rst)
        service_i |=> (status_o[31:16] == $past(reload_i)));

    a_r8_flags_never_set: assert property (@(posedge clk) disable iff (rst)
        (status_o[15:8] != '0) |=> ((status_o[15:8] & ~$past(status_o[15:8])) == '0));

    a_r8_zero_flags_stay: assert property (@(posedge clk) disable iff (rst)
        (status_o[15:8] == '0) |=> (status_o[15:8] == '0));

    a_r9_exit_needs_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(status_o[1]) |-> (status_o[15:8] == '0));

    a_r9_no_reentry: assert property (@(posedge clk) disable iff (rst)
        !status_o[1] |=> !status_o[1]);

    a_r10_disabled_frozen: assert property (@(posedge clk) disable iff (rst)
        (status_o[3] && !service_i) |=> $stable(status_o[31:16]));

endmodule

bind wdg_protected wdg_checker i_wdg_checker (
    .clk          (clk),
    .rst          (rst),
    .ctrl_wr_i    (ctrl_wr_i),
    .ctrl_rdata_o (ctrl_rdata_o),
    .prot_wr_i    (prot_wr_i),
    .prot_wdata_i (prot_wdata_i),
    .service_i    (service_i),
    .reload_i     (reload_i),
    .status_o     (status_o),
    .timeout_o    (timeout_o)
);

// File: tb/test_wdg_protected.sv
module test_wdg_protected;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode = 1'b1;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic        prot_wr = 1'b0;
    logic        prot_wdata = 1'b0;
    logic        service = 1'b0;
    logic [15:0] reload = '0;
    logic [31:0] status;
    logic        timeout;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [31:0] m_ctrl;
    logic        m_prot, m_dis, m_fast, m_scm;
    logic [7:0]  m_err;

    always #10ns clk = ~clk;

    wdg_protected i_wdg_protected (
        .clk            (clk),
        .rst            (rst),
        .selfchk_mode_i (mode),
        .ctrl_wr_i      (ctrl_wr),
        .ctrl_wdata_i   (ctrl_wdata),
        .ctrl_rdata_o   (ctrl_rdata),
        .prot_wr_i      (prot_wr),
        .prot_wdata_i   (prot_wdata),
        .service_i      (service),
        .reload_i       (reload),
        .status_o       (status),
        .timeout_o      (timeout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] f_merge(input logic [31:0] d, input logic [31:0] cur,
                                             input logic locked);
        logic [31:0] r;
        r = '0;
        r[10:8] = d[10:8];
        r[3:2]  = locked ? cur[3:2] : d[3:2];
        return r;
    endfunction

    function automatic logic [15:0] f_low();
        return {m_err, 4'b0000, m_dis, m_fast, m_scm, m_prot};
    endfunction

    task automatic do_reset(input logic md);
        @(negedge clk);
        rst = 1'b1;
        mode = md;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_ctrl = '0; m_prot = 1'b0; m_dis = 1'b0; m_fast = 1'b0;
        m_err = {8{md}}; m_scm = md;
    endtask

    task automatic drive_ctrl(input logic [31:0] d);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_wdata = d;
        @(negedge clk);
        ctrl_wr = 1'b0;
        m_ctrl = f_merge(d, m_ctrl, m_prot);
    endtask

    task automatic drive_prot(input logic b);
        @(negedge clk);
        prot_wr = 1'b1; prot_wdata = b;
        @(negedge clk);
        prot_wr = 1'b0;
        if (b) begin
            m_dis  = m_ctrl[3];
            m_fast = m_ctrl[2];
            m_err[m_ctrl[10:8]] = 1'b0;
            if (m_scm && !mode && (m_err == 8'h00)) m_scm = 1'b0;
        end
        m_prot = b;
    endtask

    task automatic do_service(input logic [15:0] v);
        @(negedge clk);
        service = 1'b1; reload = v;
        @(negedge clk);
        service = 1'b0;
        chk("R7 service load", {16'h0, status[31:16]}, {16'h0, v});
    endtask

    // Called right after a commit edge: count must move exactly one period later.
    task automatic measure_tick(input int period, input string tag);
        logic [15:0] c0;
        c0 = status[31:16];
        repeat (period - 1) @(negedge clk);
        chk({tag, " before full period"}, {16'h0, status[31:16]}, {16'h0, c0});
        @(negedge clk);
        chk({tag, " at full period"}, {16'h0, status[31:16]}, {16'h0, c0 + 16'd1});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
        $finish;
    end

    initial begin
        int pulses;
        int pulse_at;
        void'($urandom(32'h5EED_0042));

        // R1: reset with self-check mode
        do_reset(1'b1);
        chk("R1 status after reset (self-check)", status, 32'hFFFC_FF02);
        chk("R1 control after reset", ctrl_rdata, 32'h0);
        chk("R1 timeout after reset", {31'h0, timeout}, 32'h0);

        // R2: only defined bits store
        drive_ctrl(32'hFFFF_FFFF);
        chk("R2 reserved bits read zero", ctrl_rdata, 32'h0000_070C);

        // R4/R8: commit disable+fast, clear flag 7
        drive_prot(1'b1);
        chk("R4 R8 commit loads settings and clears flag", {16'h0, status[15:0]}, {16'h0, f_low()});

        // R3: locked write keeps requests, takes index
        drive_ctrl(32'h0000_0000);
        chk("R3 locked write", ctrl_rdata, 32'h0000_000C);
        chk("R4 no commit keeps live bits", {16'h0, status[15:0]}, {16'h0, f_low()});
        drive_prot(1'b0);
        chk("R4 writing zero does not commit", {16'h0, status[15:0]}, {16'h0, f_low()});

        // R10: disabled counter holds
        begin
            logic [15:0] c0;
            c0 = status[31:16];
            repeat (600) @(negedge clk);
            chk("R10 disabled count frozen", {16'h0, status[31:16]}, {16'h0, c0});
        end

        // R7 then R5 fast rate then R6 timeout
        do_service(16'hFFF0);
        drive_ctrl(32'h0000_0004);
        drive_prot(1'b1);
        measure_tick(256, "R5 fast rate from disabled");
        pulses = 0;
        pulse_at = 0;
        for (int i = 1; i <= 3700; i++) begin
            @(negedge clk);
            if (timeout) begin
                pulses++;
                pulse_at = i;
            end
        end
        chk("R6 exactly one timeout pulse", pulses, 1);
        chk("R6 pulse cycle", pulse_at, 3584);
        chk("R6 count holds at max", {16'h0, status[31:16]}, 32'h0000_FFFF);

        // R5 restart on rate change: fast -> slow after partial period
        drive_prot(1'b0);
        drive_ctrl(32'h0000_0000);
        do_service(16'h0000);
        repeat (100) @(negedge clk);
        drive_prot(1'b1);
        measure_tick(16384, "R5 slow rate restart");
        // slow -> fast after partial period
        drive_prot(1'b0);
        drive_ctrl(32'h0000_0004);
        repeat (37) @(negedge clk);
        drive_prot(1'b1);
        measure_tick(256, "R5 fast rate restart");

        // R8/R9: clear flags one index per commit, mode low
        mode = 1'b0;
        for (int k = 1; k < 8; k++) begin
            drive_prot(1'b0);
            drive_ctrl({21'h0, 3'(k), 8'h04});
            drive_prot(1'b1);
            chk("R8 R9 indexed clear and self-check exit", {16'h0, status[15:0]}, {16'h0, f_low()});
        end
        chk("R9 self-check indicator cleared", {31'h0, status[1]}, 32'h0);

        // R1 without self-check mode
        do_reset(1'b0);
        chk("R1 status after reset (no self-check)", status, 32'hFFFC_0000);

        // Random sequences from a self-check reset
        do_reset(1'b1);
        for (int n = 0; n < 500; n++) begin
            case ($urandom % 4)
                0: drive_ctrl($urandom);
                1: drive_prot(1'($urandom % 2));
                2: begin @(negedge clk); mode = ~mode; end
                default: @(negedge clk);
            endcase
            chk("R2/R3 random control readback", ctrl_rdata, m_ctrl);
            chk("R4/R8/R9 random status", {16'h0, status[15:0]}, {16'h0, f_low()});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule